// File: doc/BRIEF.md
# Three-Phase Reactive Energy Sign-Change Interrupt Unit

This block watches the direction of reactive energy flow on three phases. On every cycle that the sample strobe is high it adds one signed power sample per phase into a first-stage accumulator for that phase. Whenever an accumulator reaches the programmable quantum, either positive or negative, the block moves one quantum out of the accumulator. It then steps a 32-bit per-phase energy counter up or down by one and notes the sign of that quantum.

The sign is looked at only at these quantum crossings, never on single samples. When a crossing carries a different sign from the last crossing on the same phase, two things happen in the same clock cycle: the phase's status flag is set, and its sign flag is rewritten. If the matching mask bit is set, an active-low interrupt line is pulled low. Software reaches the flags, the mask, the quantum and the three energy counters through a simple single-cycle register port. Status flags are cleared by writing a 1 to them.

Top module: `qsm_top`

## Requirements
- R1: After a synchronous reset, the status, mask, sign and threshold registers, the three energy counters and all accumulators read 0, the stored previous sign of each phase is positive, and `irq_n` is 1.
- R2: On each cycle with `smp_en` high, every phase adds its sign-extended sample to its accumulator. If the sum is at least +threshold, the threshold is subtracted and the energy counter increments. Otherwise, if the sum is at most -threshold, the threshold is added and the counter decrements. Only one crossing can occur per sample.
- R3: Each energy counter is 32 bits wide and wraps in two's complement (one decrement from 0 reads 0xFFFFFFFF). It changes by at most one per cycle.
- R4: A crossing whose sign differs from that phase's previous crossing sets status bit 10+p and writes sign bit 4+p in the same cycle (phase A p=0, B p=1, C p=2; sign 0 = positive, 1 = negative). A crossing with an unchanged sign sets nothing.
- R5: `irq_n` is 0 exactly when some status bit in 12:10 is set while its mask bit is also set. It follows the status and mask registers in the same cycle that they change.
- R6: Writing to address 0 clears each status bit where the written data has a 1. Bits written as 0 are left as they are.
- R7: If a status bit is cleared in the same cycle that a new sign change sets it, the bit stays set.
- R8: A threshold of 0 disables crossings: the energy counters, status and sign bits do not change, whatever samples arrive.
- R9: The three phases are independent: samples on one phase never change another phase's accumulator, energy, sign or status.
- R10: The register map is: 0 status (bits 12:10), 1 mask (bits 12:10, read/write), 2 sign (bits 6:4, read-only), 3 threshold (32-bit unsigned, read/write), 4/5/6 energy of A/B/C (read-only). `reg_rdata` returns the addressed register one clock after the address is presented. Writes to read-only addresses have no effect.
- R11: Mask bits other than 12:10 read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Sample strobe; the three samples are valid when high |
| smp_a | input | PWR_W | Signed power sample, phase A |
| smp_b | input | PWR_W | Signed power sample, phase B |
| smp_c | input | PWR_W | Signed power sample, phase C |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data, one cycle after address |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Directed patterns first. Steady same-sign samples show that quanta are counted without raising events. A reversal on one phase then shows that the event fires only at a crossing, not at the first negative sample, and that the other phases stay untouched. A single large sample that exceeds the quantum tells apart a single crossing from repeated subtraction. A sign change that lands on the same cycle as a clearing write shows which of the two has priority. Streams with a zero threshold separate a disabled unit from one that merely has quiet inputs. Constrained-random bipolar samples per phase are then mixed with random mask rewrites, clearing writes and threshold changes, and compared against a bench model at periodic register reads and at `irq_n` on every cycle.

// File: rtl/qsm_pkg.sv
package qsm_pkg;
  localparam int PHASES   = 3;
  localparam int STAT_LSB = 10;
  localparam int SIGN_LSB = 4;
  localparam int ADDR_W   = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_STAT = 3'd0,
    RA_MASK = 3'd1,
    RA_SIGN = 3'd2,
    RA_THR  = 3'd3,
    RA_EN_A = 3'd4,
    RA_EN_B = 3'd5,
    RA_EN_C = 3'd6,
    RA_NONE = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/qsm_phase.sv
// One phase: first-stage accumulator, quantum extraction, energy counter
// and stored sign of the last quantum.
module qsm_phase #(
  parameter int PWR_W = 24,
  parameter int THR_W = 32,
  parameter int EN_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_en,
  input  logic signed [PWR_W-1:0] sample,
  input  logic [THR_W-1:0]        thr,
  output logic                    chg_o,
  output logic                    sign_o,
  output logic [EN_W-1:0]         energy_o
);
  localparam int ACC_W = THR_W + 2;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_sum;
  logic signed [ACC_W-1:0] thr_s;
  logic signed [ACC_W-1:0] thr_neg;
  logic                    thr_on;
  logic                    pos_hit;
  logic                    neg_hit;
  logic                    hit;
  logic                    sign_q;
  logic [EN_W-1:0]         energy_q;

  always_comb begin
    thr_s   = $signed({2'b00, thr});
    thr_neg = -thr_s;
    thr_on  = |thr;
    acc_sum = acc_q + $signed({{(ACC_W-PWR_W){sample[PWR_W-1]}}, sample});
    pos_hit = thr_on && (acc_sum >= thr_s);
    neg_hit = thr_on && !pos_hit && (acc_sum <= thr_neg);
    hit     = smp_en && (pos_hit || neg_hit);
    // neg_hit is the sign of the new quantum (1 = negative)
    chg_o   = hit && (neg_hit != sign_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      energy_q <= '0;
      sign_q   <= 1'b0;
    end else if (smp_en) begin
      if (pos_hit) begin
        acc_q    <= acc_sum - thr_s;
        energy_q <= energy_q + 1'b1;
      end else if (neg_hit) begin
        acc_q    <= acc_sum + thr_s;
        energy_q <= energy_q - 1'b1;
      end else begin
        acc_q    <= acc_sum;
      end
      if (chg_o) sign_q <= neg_hit;
    end
  end

  assign sign_o   = sign_q;
  assign energy_o = energy_q;
endmodule

// File: rtl/qsm_regs.sv
// Status / mask / threshold registers, interrupt line and read mux.
module qsm_regs
  import qsm_pkg::*;
#(
  parameter int DW    = 32,
  parameter int THR_W = 32,
  parameter int EN_W  = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_wr,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [DW-1:0]                 reg_wdata,
  input  logic [PHASES-1:0]             chg,
  input  logic [PHASES-1:0]             sign,
  input  logic [PHASES-1:0][EN_W-1:0]   energy,
  output logic [PHASES-1:0]             stat_o,
  output logic [PHASES-1:0]             mask_o,
  output logic [THR_W-1:0]              thr_o,
  output logic [DW-1:0]                 reg_rdata,
  output logic                          irq_n
);
  logic [PHASES-1:0] stat_q, stat_d;
  logic [PHASES-1:0] mask_q, mask_d;
  logic [PHASES-1:0] clr;
  logic [THR_W-1:0]  thr_q;
  logic [DW-1:0]     rd_mux;
  logic              irq_n_q;
  logic              wr_stat, wr_mask, wr_thr;

  always_comb begin
    wr_stat = reg_wr && (reg_addr == RA_STAT);
    wr_mask = reg_wr && (reg_addr == RA_MASK);
    wr_thr  = reg_wr && (reg_addr == RA_THR);
    clr     = wr_stat ? reg_wdata[STAT_LSB +: PHASES] : '0;
    // a new event beats a clearing write on the same bit
    stat_d  = (stat_q & ~clr) | chg;
    mask_d  = wr_mask ? reg_wdata[STAT_LSB +: PHASES] : mask_q;
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      RA_STAT: rd_mux[STAT_LSB +: PHASES] = stat_q;
      RA_MASK: rd_mux[STAT_LSB +: PHASES] = mask_q;
      RA_SIGN: rd_mux[SIGN_LSB +: PHASES] = sign;
      RA_THR:  rd_mux[THR_W-1:0]          = thr_q;
      default: begin
        for (int p = 0; p < PHASES; p++) begin
          if (reg_addr == ADDR_W'(RA_EN_A) + ADDR_W'(p))
            rd_mux[EN_W-1:0] = energy[p];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q    <= '0;
      mask_q    <= '0;
      thr_q     <= '0;
      irq_n_q   <= 1'b1;
      reg_rdata <= '0;
    end else begin
      stat_q    <= stat_d;
      mask_q    <= mask_d;
      if (wr_thr) thr_q <= reg_wdata[THR_W-1:0];
      irq_n_q   <= ~|(stat_d & mask_d);
      reg_rdata <= rd_mux;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign thr_o  = thr_q;
  assign irq_n  = irq_n_q;
endmodule

// File: rtl/qsm_top.sv
module qsm_top
  import qsm_pkg::*;
#(
  parameter int PWR_W = 24,
  parameter int DW    = 32,
  parameter int EN_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_en,
  input  logic signed [PWR_W-1:0] smp_a,
  input  logic signed [PWR_W-1:0] smp_b,
  input  logic signed [PWR_W-1:0] smp_c,
  input  logic                    reg_wr,
  input  logic [2:0]              reg_addr,
  input  logic [DW-1:0]           reg_wdata,
  output logic [DW-1:0]           reg_rdata,
  output logic                    irq_n
);
  localparam int THR_W = DW;

  logic signed [PHASES-1:0][PWR_W-1:0] smp_w;
  logic [PHASES-1:0]                   chg_w;
  logic [PHASES-1:0]                   sign_w;
  logic [PHASES-1:0]                   stat_w;
  logic [PHASES-1:0]                   mask_w;
  logic [PHASES-1:0][EN_W-1:0]         energy_w;
  logic [THR_W-1:0]                    thr_w;

  assign smp_w[0] = smp_a;
  assign smp_w[1] = smp_b;
  assign smp_w[2] = smp_c;

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    qsm_phase #(
      .PWR_W(PWR_W), .THR_W(THR_W), .EN_W(EN_W)
    ) u_phase (
      .clk      (clk),
      .rst      (rst),
      .smp_en   (smp_en),
      .sample   (smp_w[p]),
      .thr      (thr_w),
      .chg_o    (chg_w[p]),
      .sign_o   (sign_w[p]),
      .energy_o (energy_w[p])
    );
  end

  qsm_regs #(
    .DW(DW), .THR_W(THR_W), .EN_W(EN_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .chg       (chg_w),
    .sign      (sign_w),
    .energy    (energy_w),
    .stat_o    (stat_w),
    .mask_o    (mask_w),
    .thr_o     (thr_w),
    .reg_rdata (reg_rdata),
    .irq_n     (irq_n)
  );
endmodule

// File: rtl/qsm_checker.sv
module qsm_checker #(
  parameter int NPH   = 3,
  parameter int EN_W  = 32,
  parameter int THR_W = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  irq_n,
  input logic [NPH-1:0]        stat,
  input logic [NPH-1:0]        mask,
  input logic [NPH-1:0]        sign,
  input logic [NPH-1:0]        chg,
  input logic [THR_W-1:0]      thr,
  input logic [NPH*EN_W-1:0]   energy
);
  // R1: reset leaves flags clear and the line released
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (stat == '0) && (mask == '0) && (sign == '0) && irq_n);

  // R5: enabled pending flag drives the line low, otherwise high
  a_r5_irq_low: assert property (@(posedge clk) disable iff (rst)
    (|(stat & mask)) |-> !irq_n);
  a_r5_irq_high: assert property (@(posedge clk) disable iff (rst)
    !(|(stat & mask)) |-> irq_n);

  // R4: a sign flag only moves together with its status flag
  a_r4_sign_with_status: assert property (@(posedge clk) disable iff (rst)
    ((sign ^ $past(sign)) & ~stat) == '0);

  // R7: an event always leaves its status flag set, even against a clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|chg) |=> ((stat & $past(chg)) == $past(chg)));

  // R8: zero threshold freezes the energy counters
  a_r8_zero_thr: assert property (@(posedge clk) disable iff (rst)
    (thr == '0) |=> $stable(energy));

  // R3: energy moves by at most one count per cycle
  for (genvar p = 0; p < NPH; p++) begin : g_en
    a_r3_energy_step: assert property (@(posedge clk) disable iff (rst)
      (energy[p*EN_W +: EN_W] == $past(energy[p*EN_W +: EN_W])) ||
      (energy[p*EN_W +: EN_W] == $past(energy[p*EN_W +: EN_W]) + EN_W'(1)) ||
      (energy[p*EN_W +: EN_W] == $past(energy[p*EN_W +: EN_W]) - EN_W'(1)));
  end
endmodule

bind qsm_top qsm_checker #(
  .NPH(qsm_pkg::PHASES), .EN_W(EN_W), .THR_W(THR_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .irq_n  (irq_n),
  .stat   (stat_w),
  .mask   (mask_w),
  .sign   (sign_w),
  .chg    (chg_w),
  .thr    (thr_w),
  .energy (energy_w)
);

// File: tb/tb_qsm_top.sv
`timescale 1ns/1ps
module tb_qsm_top;
  localparam int PWR_W = 24;
  localparam int DW    = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_en = 1'b0;
  logic signed [PWR_W-1:0] smp_a = '0, smp_b = '0, smp_c = '0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq_n;

  always #5 clk = ~clk;

  qsm_top #(.PWR_W(PWR_W), .DW(DW), .EN_W(32)) dut (
    .clk(clk), .rst(rst), .smp_en(smp_en),
    .smp_a(smp_a), .smp_b(smp_b), .smp_c(smp_c),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n));

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // bench model
  int          m_acc [3];
  int          m_en  [3];
  bit          m_sgn [3];
  bit [2:0]    m_stat;
  bit [2:0]    m_mask;
  int unsigned m_thr;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic bit exp_irq_n();
    return ~|(m_stat & m_mask);
  endfunction

  task automatic model_reset();
    for (int p = 0; p < 3; p++) begin
      m_acc[p] = 0; m_en[p] = 0; m_sgn[p] = 0;
    end
    m_stat = '0; m_mask = '0; m_thr = 0;
  endtask

  // One clock: drive at negedge, update model after the edge.
  task automatic cyc(bit se, int sa, int sb, int sc,
                     bit wr, logic [2:0] a, logic [31:0] d);
    int s [3];
    bit [2:0] set_b;
    bit [2:0] clr_b;
    @(negedge clk);
    chk("R5 irq_n", {31'd0, irq_n}, {31'd0, exp_irq_n()});
    smp_en = se; smp_a = PWR_W'(sa); smp_b = PWR_W'(sb); smp_c = PWR_W'(sc);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    s[0] = sa; s[1] = sb; s[2] = sc;
    set_b = '0;
    if (se && m_thr != 0) begin
      for (int p = 0; p < 3; p++) begin
        int sum;
        bit hit;
        bit ns;
        sum = m_acc[p] + s[p];
        hit = 1'b0; ns = 1'b0;
        if (sum >= int'(m_thr)) begin
          m_acc[p] = sum - int'(m_thr); m_en[p]++; hit = 1'b1; ns = 1'b0;
        end else if (sum <= -int'(m_thr)) begin
          m_acc[p] = sum + int'(m_thr); m_en[p]--; hit = 1'b1; ns = 1'b1;
        end else m_acc[p] = sum;
        if (hit && ns != m_sgn[p]) begin
          set_b[p] = 1'b1; m_sgn[p] = ns;
        end
      end
    end else if (se) begin
      for (int p = 0; p < 3; p++) m_acc[p] += s[p];
    end
    clr_b = (wr && a == 3'd0) ? d[12:10] : 3'b000;
    m_stat = (m_stat & ~clr_b) | set_b;
    if (wr && a == 3'd1) m_mask = d[12:10];
    if (wr && a == 3'd3) m_thr  = d;
  endtask

  task automatic rd(string req, logic [2:0] a, logic [31:0] exp);
    cyc(0, 0, 0, 0, 0, a, '0);
    @(negedge clk);
    chk(req, reg_rdata, exp);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    cyc(0, 0, 0, 0, 1, a, d);
  endtask

  task automatic rd_all(string req);
    rd({req, " status"}, 3'd0, 32'(m_stat) << 10);
    rd({req, " mask"},   3'd1, 32'(m_mask) << 10);
    rd({req, " sign"},   3'd2, 32'({m_sgn[2], m_sgn[1], m_sgn[0]}) << 4);
    rd({req, " thr"},    3'd3, m_thr);
    for (int p = 0; p < 3; p++)
      rd({req, " energy"}, 3'(4 + p), 32'(m_en[p]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0123));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state
    chk("R1 irq_n after reset", {31'd0, irq_n}, 32'd1);
    rd_all("R1");

    // R8: zero threshold, large samples produce nothing
    for (int k = 0; k < 6; k++) cyc(1, 3000000, -3000000, 5000000, 0, 0, 0);
    rd("R8 energy A", 3'd4, 32'd0);
    rd("R8 energy B", 3'd5, 32'd0);
    rd("R8 status",   3'd0, 32'd0);
    rd("R8 sign",     3'd2, 32'd0);
    // drain the accumulators left by the disabled phase
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0; model_reset();

    // R10: threshold and mask register read-back, upper mask bits 0 (R11)
    wr(3'd3, 32'd100);
    rd("R10 thr readback", 3'd3, 32'd100);
    wr(3'd1, 32'hFFFF_FFFF);
    rd("R11 mask readback", 3'd1, 32'h0000_1C00);
    wr(3'd1, 32'd0);

    // R2: positive quanta on phase A, no sign change
    cyc(1, 60, 0, 0, 0, 0, 0);
    cyc(1, 60, 0, 0, 0, 0, 0);
    rd("R2 energy A +1", 3'd4, 32'd1);
    rd("R4 no event on same sign", 3'd0, 32'd0);

    // R4: reversal fires only at the crossing
    cyc(1, -70, 0, 0, 0, 0, 0);
    rd("R4 no event before crossing", 3'd0, 32'd0);
    cyc(1, -70, 0, 0, 0, 0, 0);
    rd("R4 status A set", 3'd0, 32'h0000_0400);
    rd("R4 sign A negative", 3'd2, 32'h0000_0010);
    rd("R2 energy A back to 0", 3'd4, 32'd0);
    chk("R5 masked event keeps irq high", {31'd0, irq_n}, 32'd1);

    // R10: writes to read-only registers ignored
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd4, 32'h1234_5678);
    rd("R10 sign unchanged", 3'd2, 32'h0000_0010);
    rd("R10 energy unchanged", 3'd4, 32'd0);

    // R5: unmask -> line low
    wr(3'd1, 32'h0000_1C00);
    @(negedge clk);
    chk("R5 irq low", {31'd0, irq_n}, 32'd0);

    // R6: writing 0 leaves status; writing 1 clears
    wr(3'd0, 32'h0000_0000);
    rd("R6 zero write keeps", 3'd0, 32'h0000_0400);
    wr(3'd0, 32'h0000_0400);
    rd("R6 clear", 3'd0, 32'd0);
    chk("R5 irq high after clear", {31'd0, irq_n}, 32'd1);

    // R9 / R3: phase B goes negative, wraps to all ones; A untouched
    cyc(1, 0, -150, 0, 0, 0, 0);
    rd("R3 energy B wraps", 3'd5, 32'hFFFF_FFFF);
    rd("R9 energy A untouched", 3'd4, 32'd0);
    rd("R9 status B only", 3'd0, 32'h0000_0800);
    rd("R9 sign A,B negative", 3'd2, 32'h0000_0030);

    // R7 + R2: one big sample (single crossing) while clearing B
    cyc(1, 0, 300, 0, 1, 3'd0, 32'h0000_0800);
    rd("R7 set wins over clear", 3'd0, 32'h0000_0800);
    rd("R2 single crossing", 3'd5, 32'd0);
    rd("R4 sign B positive", 3'd2, 32'h0000_0010);
    wr(3'd0, 32'h0000_1C00);

    // constrained random run
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 2)
        wr(3'd3, 32'($urandom_range(50, 800)));
      else if (r < 5)
        wr(3'd1, 32'($urandom_range(0, 7)) << 10);
      else if (r < 9)
        wr(3'd0, 32'($urandom_range(0, 7)) << 10);
      else
        cyc(1, int'($urandom_range(0, 3000)) - 1500,
               int'($urandom_range(0, 2000)) - 1000,
               int'($urandom_range(0, 1200)) - 600, 0, 0, 0);
      if (k % 64 == 63) rd_all("R2/R4 random");
    end
    rd_all("R2/R4 final");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule